// File: doc/BRIEF.md
# Gated Pixel-Clock Frequency Meter

This block estimates the rate of an incoming pixel clock in whole megahertz, using only a free-running reference clock. A timer in the reference domain opens a short measurement gate of about 4 µs once in every period of about 10 µs. The pixel clock drives a free-running edge counter of its own, so its rate needs no relation to the reference rate. That count crosses into the reference domain as a Gray code. The block samples it when the gate opens and again when the gate closes, and the difference between the two samples is the number of rising edges seen during the gate.

When the gate closes, the edge count is divided by four to give megahertz. The result is clipped to the largest value the output field can hold. A status bit reports whether a clock appears to be present, which means at least four edges fell inside the gate. Both results are registered and hold their values until the next refresh. A one-cycle strobe marks each refresh. The status bit depends only on the edge count, so any input that toggles at a valid rate sets it, noise included. It says nothing about whether a downstream PLL has locked.

Top module: `pclk_freq_meter`

## Requirements
- R1: While `ref_rst` is high, `freq_mhz` and `clk_present` read 0 and `update_stb` is 0 from the next reference edge onward.
- R2: `update_stb` is a single-cycle pulse, and consecutive pulses are exactly REF_MHZ×PER_US reference cycles apart (1250 cycles with a 125 MHz reference and a 10 µs period).
- R3: On each refresh, `freq_mhz` equals the number of pixel-clock rising edges counted during a gate of REF_MHZ×WIN_US reference cycles, divided by 4 and rounded down. Gate phase and synchronizer sampling can move the count by one edge, so the result may differ by 1 from the nominal value.
- R4: `clk_present` is 1 after a refresh exactly when the gate counted 4 or more edges. A 2 MHz input sets it, and a 0.5 MHz input (at most 3 edges) never does.
- R5: When the quotient is larger than 2^FREQ_W−1, `freq_mhz` saturates at 2^FREQ_W−1 and does not wrap. With FREQ_W=6, a 100 MHz input reads 63.
- R6: After the pixel clock stops, the first gate that lies wholly after the stop reports `freq_mhz`=0 and `clk_present`=0.
- R7: Between refreshes, `freq_mhz` and `clk_present` keep their last values.
- R8: After every refresh, `clk_present` is 1 exactly when `freq_mhz` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock, REF_MHZ megahertz |
| ref_rst | input | 1 | Active-high reset. Synchronous in the reference domain; it also clears the pixel-domain counter asynchronously |
| pix_clk | input | 1 | Pixel clock under measurement, asynchronous to `ref_clk` |
| freq_mhz | output | FREQ_W | Last measured frequency in MHz, saturating |
| clk_present | output | 1 | Clock-present status from the last gate |
| update_stb | output | 1 | One-cycle pulse in the cycle where the outputs are refreshed |

## Verification
A fault in the gate timer shows up as a wrong spacing between strobes, and it is visible at the second strobe after reset. A wrong snapshot, a broken synchronizer or a wrong division shows up as a wrong `freq_mhz` at the first refresh whose gate lies wholly inside a stable input rate. That refresh comes at most two update periods after a change in the stimulus. A fault in the saturation or threshold logic appears only at the rate extremes (0.5 MHz, 2 MHz, stopped, faster than the field can hold), so the stimulus covers each of those. A fault in the hold logic appears as an output that changes in a cycle with no strobe.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Smallest edge count that counts as a present clock, and the
    // shift that turns edges per 4 us into MHz.
    localparam int unsigned MIN_EDGES = 4;
    localparam int unsigned DIV_SHIFT = 2;

    // Gate events raised by the timer, one cycle each.
    typedef struct packed {
        logic open_pulse;
        logic close_pulse;
    } gate_evt_t;

    function automatic int unsigned cycles_for_us(int unsigned ref_mhz, int unsigned us);
        return ref_mhz * us;
    endfunction

    function automatic int unsigned bits_for(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pfd_edge_counter.sv
module pfd_edge_counter #(
    parameter int CW = 12
) (
    input  logic          pix_clk,
    input  logic          arst,
    output logic [CW-1:0] gray_q
);
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;

    assign bin_nx = bin_q + CW'(1);

    // Free-running count of pixel rising edges, published as Gray code.
    always_ff @(posedge pix_clk or posedge arst) begin
        if (arst) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/pfd_gray_sync.sv
module pfd_gray_sync #(
    parameter int CW     = 12,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] gray_in,
    output logic [CW-1:0] bin_out
);
    logic [CW-1:0] stage_q [STAGES];
    logic [CW-1:0] bin_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= gray_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits.
    always_comb begin
        for (int i = 0; i < CW; i++) bin_c[i] = ^(stage_q[STAGES-1] >> i);
    end

    always_ff @(posedge clk) begin
        if (rst) bin_out <= '0;
        else     bin_out <= bin_c;
    end
endmodule

// File: rtl/pfd_gate_timer.sv
module pfd_gate_timer
    import pfd_pkg::*;
#(
    parameter int PER_CYC = 1000,
    parameter int WIN_CYC = 400
) (
    input  logic      clk,
    input  logic      rst,
    output gate_evt_t evt
);
    localparam int TW = bits_for(PER_CYC);
    localparam logic [TW-1:0] LAST  = TW'(PER_CYC - 1);
    localparam logic [TW-1:0] CLOSE = TW'(WIN_CYC);

    logic [TW-1:0] tick_q;

    always_ff @(posedge clk) begin
        if (rst)                 tick_q <= '0;
        else if (tick_q == LAST) tick_q <= '0;
        else                     tick_q <= tick_q + TW'(1);
    end

    assign evt.open_pulse  = (tick_q == '0);
    assign evt.close_pulse = (tick_q == CLOSE);
endmodule

// File: rtl/pclk_freq_meter.sv
module pclk_freq_meter
    import pfd_pkg::*;
#(
    parameter int REF_MHZ     = 100,
    parameter int WIN_US      = 4,
    parameter int PER_US      = 10,
    parameter int CNT_W       = 12,
    parameter int FREQ_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              ref_clk,
    input  logic              ref_rst,
    input  logic              pix_clk,
    output logic [FREQ_W-1:0] freq_mhz,
    output logic              clk_present,
    output logic              update_stb
);
    localparam int WIN_CYC = cycles_for_us(REF_MHZ, WIN_US);
    localparam int PER_CYC = cycles_for_us(REF_MHZ, PER_US);
    localparam int QUO_W   = CNT_W - DIV_SHIFT;

    gate_evt_t         evt;
    logic [CNT_W-1:0]  pix_gray;
    logic [CNT_W-1:0]  sync_bin;
    logic [CNT_W-1:0]  start_snap;
    logic [CNT_W-1:0]  window_cnt;
    logic [QUO_W-1:0]  quotient;
    logic [FREQ_W-1:0] freq_nx;
    logic              present_nx;

    pfd_edge_counter #(.CW(CNT_W)) u_cnt (
        .pix_clk (pix_clk),
        .arst    (ref_rst),
        .gray_q  (pix_gray)
    );

    pfd_gray_sync #(.CW(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (ref_clk),
        .rst     (ref_rst),
        .gray_in (pix_gray),
        .bin_out (sync_bin)
    );

    pfd_gate_timer #(.PER_CYC(PER_CYC), .WIN_CYC(WIN_CYC)) u_gate (
        .clk (ref_clk),
        .rst (ref_rst),
        .evt (evt)
    );

    assign window_cnt = sync_bin - start_snap;
    assign quotient   = window_cnt[CNT_W-1:DIV_SHIFT];
    assign present_nx = (window_cnt >= CNT_W'(MIN_EDGES));

    generate
        if (QUO_W > FREQ_W) begin : g_sat
            localparam logic [QUO_W-1:0] MAXV = QUO_W'((1 << FREQ_W) - 1);
            assign freq_nx = (quotient > MAXV) ? '1 : quotient[FREQ_W-1:0];
        end else begin : g_ext
            assign freq_nx = FREQ_W'(quotient);
        end
    endgenerate

    always_ff @(posedge ref_clk) begin
        if (ref_rst) begin
            start_snap  <= '0;
            freq_mhz    <= '0;
            clk_present <= 1'b0;
            update_stb  <= 1'b0;
        end else begin
            update_stb <= evt.close_pulse;
            if (evt.open_pulse) start_snap <= sync_bin;
            if (evt.close_pulse) begin
                freq_mhz    <= freq_nx;
                clk_present <= present_nx;
            end
        end
    end
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
    parameter int PER_CYC = 1000,
    parameter int FREQ_W  = 8
) (
    input logic              ref_clk,
    input logic              ref_rst,
    input logic [FREQ_W-1:0] freq_mhz,
    input logic              clk_present,
    input logic              update_stb
);
    localparam int GW = $clog2(PER_CYC + 1);
    localparam logic [GW-1:0] GMAX = GW'(PER_CYC);

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge ref_clk) begin
        if (ref_rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (update_stb) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GMAX) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    assert_reset_clear_R1: assert property (@(posedge ref_clk)
        ref_rst |=> (freq_mhz == '0 && !clk_present && !update_stb));

    assert_strobe_spacing_R2: assert property (@(posedge ref_clk) disable iff (ref_rst)
        (update_stb && seen_q) |-> (gap_q == GW'(PER_CYC - 1)));

    assert_strobe_single_R2: assert property (@(posedge ref_clk) disable iff (ref_rst)
        update_stb |=> !update_stb);

    assert_hold_between_R7: assert property (@(posedge ref_clk) disable iff (ref_rst)
        !update_stb |-> ($stable(freq_mhz) && $stable(clk_present)));

    assert_present_matches_R8: assert property (@(posedge ref_clk) disable iff (ref_rst)
        update_stb |-> (clk_present == (freq_mhz != '0)));
endmodule

bind pclk_freq_meter pfd_checker #(.PER_CYC(PER_CYC), .FREQ_W(FREQ_W)) u_chk (
    .ref_clk     (ref_clk),
    .ref_rst     (ref_rst),
    .freq_mhz    (freq_mhz),
    .clk_present (clk_present),
    .update_stb  (update_stb)
);

// File: tb/pclk_freq_meter_test.sv
`timescale 1ns/1ps
module pclk_freq_meter_test;
    localparam int REF_MHZ = 125;
    localparam int FREQ_W  = 6;
    localparam int PER_CYC = REF_MHZ * 10;

    typedef struct packed {
        int half_ps;   // 0 = stopped
        int exp_mhz;
        int exp_det;
        int tol;
        int kind;      // 0 rate, 1 stopped, 2 saturating, 3 threshold
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{20000,   25, 1, 1, 0},   // 25 MHz
        '{10000,   50, 1, 1, 0},   // 50 MHz
        '{0,        0, 0, 0, 1},   // stopped
        '{50000,   10, 1, 1, 0},   // 10 MHz
        '{250000,   2, 1, 1, 3},   // 2 MHz
        '{1000000,  0, 0, 0, 3},   // 0.5 MHz
        '{5000,    63, 1, 0, 2}    // 100 MHz saturates
    };

    logic              ref_clk = 1'b0;
    logic              ref_rst = 1'b1;
    logic              pix_clk = 1'b0;
    logic [FREQ_W-1:0] freq_mhz;
    logic              clk_present;
    logic              update_stb;
    real               pix_half_ns = 0.0;
    int                checks = 0;
    int                fails  = 0;

    pclk_freq_meter #(.REF_MHZ(REF_MHZ), .FREQ_W(FREQ_W)) uut (
        .ref_clk     (ref_clk),
        .ref_rst     (ref_rst),
        .pix_clk     (pix_clk),
        .freq_mhz    (freq_mhz),
        .clk_present (clk_present),
        .update_stb  (update_stb)
    );

    always #4 ref_clk = ~ref_clk;

    always begin
        if (pix_half_ns > 0.0) begin
            #(pix_half_ns) pix_clk = ~pix_clk;
        end else begin
            #5;
        end
    end

    task automatic check(input string req, input int act, input int exp, input int tol);
        int d;
        checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
        end
    endtask

    task automatic next_strobe(output int gap);
        gap = 0;
        do begin
            @(negedge ref_clk);
            gap++;
        end while (!update_stb);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge ref_clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int    g;
        int    f0;
        int    d0;
        string tag;
        repeat (5) @(negedge ref_clk);
        // R1: reset state
        check("R1 freq", int'(freq_mhz), 0, 0);
        check("R1 present", int'(clk_present), 0, 0);
        check("R1 strobe", int'(update_stb), 0, 0);
        ref_rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            pix_half_ns = real'(VECS[v].half_ps) / 1000.0;
            next_strobe(g);
            next_strobe(g);
            check("R2 spacing", g, PER_CYC, 0);
            next_strobe(g);
            tag = (VECS[v].kind == 1) ? "R6" : (VECS[v].kind == 2) ? "R5" : "R3";
            check(tag, int'(freq_mhz), VECS[v].exp_mhz, VECS[v].tol);
            check((VECS[v].kind == 1) ? "R6 present" : "R4 present",
                  int'(clk_present), VECS[v].exp_det, 0);
            check("R8 present vs freq", int'(clk_present), int'(freq_mhz != '0), 0);
            f0 = int'(freq_mhz);
            d0 = int'(clk_present);
            @(negedge ref_clk);
            check("R2 pulse width", int'(update_stb), 0, 0);
            repeat (600) @(negedge ref_clk);
            check("R7 hold freq", int'(freq_mhz), f0, 0);
            check("R7 hold present", int'(clk_present), d0, 0);
        end

        // R1: reset in mid-run clears the held results
        ref_rst = 1'b1;
        repeat (3) @(negedge ref_clk);
        check("R1 rerun freq", int'(freq_mhz), 0, 0);
        check("R1 rerun present", int'(clk_present), 0, 0);
        ref_rst = 1'b0;
        pix_half_ns = 0.0;
        finish_run();
    end
endmodule